// File: doc/BRIEF.md
# Dual-Port Bank-Select Configuration Register

This block holds a small configuration word that two serial-bus ports can both reach. Each port hands the block an already-decoded byte stream: a START pulse, a STOP pulse, and a strobe for every byte received from the controller. The block answers each byte with an acknowledge bit. When a read is open, it presents the register value for the port's byte transmitter. The stored word keeps a write-enable flag, two bank-control bits and a single-bank flag. It is modelled as an ordinary register that loads a default at reset, standing in for nonvolatile storage.

The active memory bank is worked out from the stored bits and an external select pin. A mode bit chooses whether the pin or a register bit picks the bank. The single-bank flag overrides both. The write-enable flag gates configuration writes from one designated port only. Every other port can always write. The flag is also driven out so that the memory array can gate its own writes from that port.

Top module: `cfgreg_bank_sel`

## Requirements
- R1: After reset the stored word is 0x00. The read byte is 0x00, `gated_wr_en` is 0 and `active_bank` equals `bank_pin`.
- R2: A transaction whose address byte is 0x63 is acknowledged and raises that port's `i2c_rd_sel`. `rd_byte` carries the stored fields in bits 3..0: WE in bit 3, AB1 in bit 2, AB0 in bit 1 and NB in bit 0. Bits 7..4 read as zero.
- R3: A write is address byte 0x62, then one dummy byte, then the data byte, and each of the three is acknowledged. The new value appears only after the STOP. Bits 7..4 of the data byte are dropped.
- R4: Any other address byte is not acknowledged. Later bytes in that transaction are not acknowledged and do not change the register.
- R5: When NB (bit 0) is 1, `active_bank` is 0 (lower) whatever the other bits and the pin are.
- R6: When NB=0 and AB1 (bit 2) is 0, `active_bank` follows `bank_pin`.
- R7: When NB=0 and AB1=1, `active_bank` equals AB0 (bit 1).
- R8: While WE (bit 3) is 0, a data byte from the gated port (index `GATED_PORT`, default 1) is not acknowledged and the register keeps its value.
- R9: Port 0 writes whatever WE is. With WE=1 the gated port writes as well. `gated_wr_en` equals WE.
- R10: A repeated START or a STOP before the data byte abandons the write. A byte after the data byte is not acknowledged, and the write still takes effect at STOP.
- R11: When two ports complete writes in the same cycle, the lowest-numbered port's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the default word |
| i2c_start | input | NPORT | Per-port START (or repeated START) pulse |
| i2c_stop | input | NPORT | Per-port STOP pulse |
| i2c_byte_vld | input | NPORT | Per-port strobe: a byte from the controller is complete |
| i2c_byte | input | 8*NPORT | Per-port received byte, port i in bits 8i+7..8i |
| bank_pin | input | 1 | External bank select pin |
| i2c_ack | output | NPORT | Acknowledge for the byte strobed one cycle earlier |
| i2c_rd_sel | output | NPORT | Port has an open register read |
| rd_byte | output | 8 | Register read-back value |
| active_bank | output | 1 | 0 = lower bank, 1 = upper bank |
| gated_wr_en | output | 1 | Write permission for the gated port's memory accesses |

## Verification
The assertions take for granted that each port's decoder never raises START, STOP and a byte strobe in the same cycle. They also assume a byte strobe lasts exactly one cycle, so an acknowledge can always be traced back to a strobe one cycle earlier. The bench drives every event as a single-cycle pulse on its own falling edge and leaves idle cycles between them. The only cycle where two ports act together is the shared STOP in the priority test.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int CFG_W = 4;

  typedef struct packed {
    logic we;
    logic ab1;
    logic ab0;
    logic nb;
  } cfg_t;

  typedef enum logic [2:0] {
    PS_IDLE, PS_ADDR, PS_WDUMMY, PS_WDATA, PS_WHOLD, PS_RD, PS_SKIP
  } pst_t;

  function automatic logic pick_bank(cfg_t c, logic pin);
    if (c.nb)  return 1'b0;
    if (c.ab1) return c.ab0;
    return pin;
  endfunction

  function automatic logic [7:0] readback(cfg_t c);
    return {4'b0000, c};
  endfunction
endpackage

// File: rtl/cfgreg_port.sv
module cfgreg_port
  import cfgreg_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = 8'h62,
  parameter logic [7:0] RD_ADDR = 8'h63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       stop,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       wr_allow,
  output logic       ack,
  output logic       rd_sel,
  output logic       wr_stb,
  output cfg_t       wr_data
);
  pst_t st_q, st_d;
  cfg_t hold_q, hold_d;
  logic ack_d;

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    ack_d  = 1'b0;
    wr_stb = 1'b0;
    if (start) begin
      st_d = PS_ADDR;
    end else if (stop) begin
      wr_stb = (st_q == PS_WHOLD) && wr_allow;
      st_d   = PS_IDLE;
    end else if (byte_vld) begin
      unique case (st_q)
        PS_ADDR: begin
          if (byte_in == WR_ADDR) begin
            st_d = PS_WDUMMY; ack_d = 1'b1;
          end else if (byte_in == RD_ADDR) begin
            st_d = PS_RD; ack_d = 1'b1;
          end else begin
            st_d = PS_SKIP;
          end
        end
        PS_WDUMMY: begin
          st_d = PS_WDATA; ack_d = 1'b1;
        end
        PS_WDATA: begin
          if (wr_allow) begin
            hold_d = cfg_t'(byte_in[CFG_W-1:0]);
            st_d   = PS_WHOLD;
            ack_d  = 1'b1;
          end else begin
            st_d = PS_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      hold_q <= '0;
      ack    <= 1'b0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
      ack    <= ack_d;
    end
  end

  assign rd_sel  = (st_q == PS_RD);
  assign wr_data = hold_q;
endmodule

// File: rtl/cfgreg_bank_sel.sv
module cfgreg_bank_sel
  import cfgreg_pkg::*;
#(
  parameter int         NPORT      = 2,
  parameter int         GATED_PORT = 1,
  parameter logic [7:0] WR_ADDR    = 8'h62,
  parameter logic [7:0] RD_ADDR    = 8'h63,
  parameter logic [3:0] RST_VAL    = 4'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT-1:0]   i2c_start,
  input  logic [NPORT-1:0]   i2c_stop,
  input  logic [NPORT-1:0]   i2c_byte_vld,
  input  logic [8*NPORT-1:0] i2c_byte,
  input  logic               bank_pin,
  output logic [NPORT-1:0]   i2c_ack,
  output logic [NPORT-1:0]   i2c_rd_sel,
  output logic [7:0]         rd_byte,
  output logic               active_bank,
  output logic               gated_wr_en
);
  cfg_t             cfg_q;
  logic [NPORT-1:0] port_stb;
  cfg_t             port_data [NPORT];
  logic             commit_any;
  cfg_t             commit_val;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic allow;
    if (i == GATED_PORT) begin : g_gated
      assign allow = cfg_q.we;
    end else begin : g_free
      assign allow = 1'b1;
    end
    cfgreg_port #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (i2c_start[i]),
      .stop     (i2c_stop[i]),
      .byte_vld (i2c_byte_vld[i]),
      .byte_in  (i2c_byte[8*i +: 8]),
      .wr_allow (allow),
      .ack      (i2c_ack[i]),
      .rd_sel   (i2c_rd_sel[i]),
      .wr_stb   (port_stb[i]),
      .wr_data  (port_data[i])
    );
  end

  // lowest index wins: scan downwards so it is assigned last
  always_comb begin
    commit_val = cfg_q;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (port_stb[i]) commit_val = port_data[i];
    end
  end
  assign commit_any = |port_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= cfg_t'(RST_VAL);
    else if (commit_any) cfg_q <= commit_val;
  end

  assign rd_byte     = readback(cfg_q);
  assign active_bank = pick_bank(cfg_q, bank_pin);
  assign gated_wr_en = cfg_q.we;
endmodule

// File: rtl/cfgreg_bank_sel_chk.sv
module cfgreg_bank_sel_chk #(
  parameter int NPORT      = 2,
  parameter int GATED_PORT = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] i2c_byte_vld,
  input logic [NPORT-1:0] i2c_ack,
  input logic [7:0]       rd_byte,
  input logic             bank_pin,
  input logic             active_bank,
  input logic [3:0]       cfg_q,
  input logic [NPORT-1:0] port_stb,
  input logic             commit_any
);
  a_r5_nb_forces_lower: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[0] |-> !active_bank);
  a_r6_pin_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[0] && !cfg_q[2]) |-> (active_bank == bank_pin));
  a_r7_ab0_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[0] && cfg_q[2]) |-> (active_bank == cfg_q[1]));
  a_r8_gated_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_stb[GATED_PORT] && !cfg_q[3]));
  a_r3_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    |i2c_ack |-> ((i2c_ack & ~$past(i2c_byte_vld)) == '0));
  a_r9_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_any |=> $stable(cfg_q));
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_byte[7:4] == 4'h0);
endmodule

bind cfgreg_bank_sel cfgreg_bank_sel_chk #(.NPORT(NPORT), .GATED_PORT(GATED_PORT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .i2c_byte_vld (i2c_byte_vld),
  .i2c_ack      (i2c_ack),
  .rd_byte      (rd_byte),
  .bank_pin     (bank_pin),
  .active_bank  (active_bank),
  .cfg_q        (cfg_q),
  .port_stb     (port_stb),
  .commit_any   (commit_any)
);

// File: tb/tb_cfgreg_bank_sel.sv
module tb_cfgreg_bank_sel;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  i2c_start = 0, i2c_stop = 0, i2c_byte_vld = 0;
  logic [15:0] i2c_byte = 0;
  logic        bank_pin = 0;
  logic [1:0]  i2c_ack, i2c_rd_sel;
  logic [7:0]  rd_byte;
  logic        active_bank, gated_wr_en;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cfgreg_bank_sel dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pstart(int p);
    @(negedge clk); i2c_start[p] = 1;
    @(negedge clk); i2c_start[p] = 0;
  endtask

  task automatic pstop(int p);
    @(negedge clk); i2c_stop[p] = 1;
    @(negedge clk); i2c_stop[p] = 0;
  endtask

  task automatic send(int p, logic [7:0] b, output logic a);
    @(negedge clk); i2c_byte[8*p +: 8] = b; i2c_byte_vld[p] = 1;
    @(negedge clk); i2c_byte_vld[p] = 0; a = i2c_ack[p];
  endtask

  // full write, checking the acks; data ack expectation given
  task automatic wr(int p, logic [7:0] d, logic exp_dack, string req);
    logic a;
    pstart(p);
    send(p, 8'h62, a); chk(req, a, 1);
    send(p, 8'h00, a); chk(req, a, 1);
    send(p, d, a);     chk(req, a, exp_dack);
    pstop(p);
  endtask

  task automatic t_reset;
    chk("R1", rd_byte, 8'h00);
    chk("R1", gated_wr_en, 0);
    bank_pin = 1; #1 chk("R1", active_bank, 1);
    bank_pin = 0; #1 chk("R1", active_bank, 0);
  endtask

  task automatic t_write_nb;
    logic a;
    pstart(0);
    send(0, 8'h62, a); chk("R3", a, 1);
    send(0, 8'h00, a); chk("R3", a, 1);
    send(0, 8'hF9, a); chk("R3", a, 1);
    chk("R3 before stop", rd_byte, 8'h00);
    pstop(0);
    chk("R3", rd_byte, 8'h09);
    chk("R9", gated_wr_en, 1);
    bank_pin = 1; #1 chk("R5", active_bank, 0);
    bank_pin = 0; #1 chk("R5", active_bank, 0);
  endtask

  task automatic t_read;
    logic a;
    pstart(1);
    send(1, 8'h63, a); chk("R2 ack", a, 1);
    chk("R2 rd_sel", i2c_rd_sel, 2'b10);
    chk("R2 data", rd_byte, 8'h09);
    pstop(1);
    chk("R2 closed", i2c_rd_sel, 2'b00);
  endtask

  task automatic t_ab_mode;
    wr(0, 8'h04, 1, "R7");
    bank_pin = 1; #1 chk("R7", active_bank, 0);
    wr(0, 8'h06, 1, "R7");
    bank_pin = 0; #1 chk("R7", active_bank, 1);
  endtask

  task automatic t_pin_mode;
    wr(0, 8'h00, 1, "R6");
    bank_pin = 1; #1 chk("R6", active_bank, 1);
    bank_pin = 0; #1 chk("R6", active_bank, 0);
  endtask

  task automatic t_gated_locked;
    wr(1, 8'h0F, 0, "R8");
    chk("R8", rd_byte, 8'h00);
  endtask

  task automatic t_gated_open;
    wr(0, 8'h08, 1, "R9");
    wr(1, 8'h0E, 1, "R9");
    chk("R9", rd_byte, 8'h0E);
  endtask

  task automatic t_bad_addr;
    logic a;
    pstart(0);
    send(0, 8'h50, a); chk("R4", a, 0);
    send(0, 8'h00, a); chk("R4", a, 0);
    send(0, 8'h01, a); chk("R4", a, 0);
    pstop(0);
    chk("R4", rd_byte, 8'h0E);
  endtask

  task automatic t_abort;
    logic a;
    pstart(0);
    send(0, 8'h62, a); send(0, 8'h00, a); send(0, 8'h01, a);
    pstart(0); pstop(0);
    chk("R10 restart", rd_byte, 8'h0E);
    pstart(0);
    send(0, 8'h62, a); send(0, 8'h00, a);
    pstop(0);
    chk("R10 short", rd_byte, 8'h0E);
    pstart(0);
    send(0, 8'h62, a); send(0, 8'h00, a); send(0, 8'h0A, a);
    send(0, 8'h05, a); chk("R10 extra", a, 0);
    pstop(0);
    chk("R10 commit", rd_byte, 8'h0A);
  endtask

  task automatic t_both;
    logic a;
    pstart(0); send(0, 8'h62, a); send(0, 8'h00, a); send(0, 8'h02, a);
    pstart(1); send(1, 8'h62, a); send(1, 8'h00, a); send(1, 8'h0C, a);
    chk("R11 port1 ack", a, 1);
    @(negedge clk); i2c_stop = 2'b11;
    @(negedge clk); i2c_stop = 2'b00;
    chk("R11", rd_byte, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_write_nb;
    t_read;
    t_ab_mode;
    t_pin_mode;
    t_gated_locked;
    t_gated_open;
    t_bad_addr;
    t_abort;
    wr(0, 8'h08, 1, "R11 setup");
    t_both;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule